// File: doc/BRIEF.md
# Shared-Bus Round-Robin Arbiter with Hold, Retain and Cycle Timeout

This block is the central allocator for a bus shared by several masters. Each candidate master pulls its own active-low bid line low. When the bus is free, the arbiter picks one bidder by rotating priority and asserts that device's grant in the next clock. The winner may then run any number of bus cycles without bidding again. It gives the bus up when it drops its bid while idle, or when the arbiter asks for the bus back and the master acknowledges at the end of a cycle.

A master can tag a cycle as a retained cycle. This keeps the bus locked for an indivisible sequence such as read-modify-write. While the lock is set, the arbiter neither asks for release nor accepts one. A cycle that stays busy too long is killed: the arbiter pulses an abort strobe, takes the grant away and starts arbitrating again. Interrupt flags raised by devices are only latched into sticky bits. Software or a service unit clears them.

Top module: `bus_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, `grant`, `rel_req`, `abort` and `irq_pend` are all zero. The first bidder search starts at device 0.
- R2: `grant` is one-hot or zero at all times. When the bus is idle and at least one bit of `req_n` is low at a clock edge, exactly one grant bit is set after that edge.
- R3: The arbiter searches bidders starting from the device after the last one granted, wrapping from N-1 to 0, and grants the first device found with a low bid.
- R4: An owner keeps its grant across any number of cycles while no release, timeout or voluntary drop applies, including `cyc_done` pulses with `rel_ack` low.
- R5: `rel_req` is high exactly when a device is granted, some other device's bid is low, no retain lock is set and `cyc_retain` is low in the same clock.
- R6: A `cyc_done` pulse with `rel_ack` high and `cyc_retain` low removes the grant at the next edge. The bus is re-arbitrated one clock later.
- R7: A `cyc_done` with `cyc_retain` high sets a retain lock and keeps the grant, even when `rel_ack` is high. The lock holds the grant until a later `cyc_done` with `cyc_retain` low.
- R8: With no lock set, the owner gives the bus up when its own bid line is high and both `cyc_busy` and `cyc_done` are low. The grant drops at the next edge.
- R9: If `cyc_busy` stays high without `cyc_done` for TIMEOUT consecutive owned clocks (256 by default), then at that edge `abort` rises for exactly one clock and the grant and lock clear. No grant is issued during the abort clock. Arbitration resumes the clock after.
- R10: A high `irq_in` bit sets the matching `irq_pend` bit at the next edge. A high `irq_clr` bit clears it. Setting wins when both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | N | Per-device bid, active low |
| cyc_busy | input | 1 | Owner has a bus cycle in progress |
| cyc_done | input | 1 | One-clock pulse at the end of the owner's cycle |
| cyc_retain | input | 1 | The current/ending cycle is a retained cycle |
| rel_ack | input | 1 | Owner agrees to release at this cycle end |
| irq_in | input | N | Per-device interrupt flag |
| irq_clr | input | N | Per-device clear of a latched interrupt |
| grant | output | N | Per-device grant, one-hot or zero |
| rel_req | output | 1 | Arbiter asks the owner to release |
| abort | output | 1 | One-clock strobe: stalled cycle killed |
| irq_pend | output | N | Latched interrupt flags |

## Verification
The hardest state to reach from the ports is a timeout. It needs an owner that holds `cyc_busy` high for 256 unbroken clocks with no `cyc_done`. Random stimulus almost never produces this, so a directed stretch does it, with a rival bidding the whole time so the abort must pre-empt a pending release request. A second hard spot is a retained cycle end that arrives together with `rel_ack` and a rival bid. A directed sequence sets that up, and then a long random phase mixes bids, cycle ends and retain tags against a cycle-by-cycle model.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OWN   = 2'd1,
        ST_ABORT = 2'd2
    } arb_state_e;

    typedef struct packed {
        logic busy;
        logic done;
        logic retain;
        logic ack;
    } cyc_ctl_t;

    function automatic int wrap_next(input int idx, input int n);
        return (idx == n - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  bids,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Walk from farthest offset to nearest so the nearest bidder wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int off = N - 1; off >= 0; off--) begin
            int c;
            c = (int'(start) + off) % N;
            if (bids[c]) begin
                found = 1'b1;
                idx   = IW'(c);
            end
        end
    end
endmodule

// File: rtl/arb_watchdog.sv
module arb_watchdog #(
    parameter int TIMEOUT = 256,
    localparam int CW = $clog2(TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (cnt_q == CW'(TIMEOUT - 1));
endmodule

// File: rtl/arb_irq_latch.sv
module arb_irq_latch #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           flags[g] <= 1'b0;
            else if (set_i[g]) flags[g] <= 1'b1;
            else if (clr_i[g]) flags[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
    import arb_pkg::*;
#(
    parameter int N       = 4,
    parameter int TIMEOUT = 256
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_n,
    input  logic         cyc_busy,
    input  logic         cyc_done,
    input  logic         cyc_retain,
    input  logic         rel_ack,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] irq_clr,
    output logic [N-1:0] grant,
    output logic         rel_req,
    output logic         abort,
    output logic [N-1:0] irq_pend
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    arb_state_e    state_q;
    logic [IW-1:0] owner_q;
    logic [IW-1:0] ptr_q;
    logic          lock_q;
    logic          abort_q;
    logic [N-1:0]  grant_q;

    cyc_ctl_t      ctl;
    logic [N-1:0]  bids;
    logic          pick_found;
    logic [IW-1:0] pick_idx;
    logic          wd_run;
    logic          wd_expire;
    logic          owner_bids;

    assign ctl  = '{busy: cyc_busy, done: cyc_done, retain: cyc_retain, ack: rel_ack};
    assign bids = ~req_n;

    arb_rr_pick #(.N(N)) u_pick (
        .bids  (bids),
        .start (ptr_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign wd_run = (state_q == ST_OWN) && ctl.busy && !ctl.done;

    arb_watchdog #(.TIMEOUT(TIMEOUT)) u_wd (
        .clk    (clk),
        .rst    (rst),
        .run    (wd_run),
        .expire (wd_expire)
    );

    arb_irq_latch #(.N(N)) u_irq (
        .clk   (clk),
        .rst   (rst),
        .set_i (irq_in),
        .clr_i (irq_clr),
        .flags (irq_pend)
    );

    assign owner_bids = bids[owner_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
            ptr_q   <= '0;
            lock_q  <= 1'b0;
            abort_q <= 1'b0;
            grant_q <= '0;
        end else begin
            abort_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (pick_found) begin
                        state_q          <= ST_OWN;
                        owner_q          <= pick_idx;
                        ptr_q            <= IW'(wrap_next(int'(pick_idx), N));
                        lock_q           <= 1'b0;
                        grant_q          <= '0;
                        grant_q[pick_idx] <= 1'b1;
                    end
                end
                ST_OWN: begin
                    if (wd_expire) begin
                        state_q <= ST_ABORT;
                        abort_q <= 1'b1;
                        grant_q <= '0;
                        lock_q  <= 1'b0;
                    end else if (ctl.done) begin
                        if (ctl.ack && !ctl.retain) begin
                            state_q <= ST_IDLE;
                            grant_q <= '0;
                            lock_q  <= 1'b0;
                        end else begin
                            lock_q <= ctl.retain;
                        end
                    end else if (!ctl.busy && !lock_q && !owner_bids) begin
                        state_q <= ST_IDLE;
                        grant_q <= '0;
                    end
                end
                ST_ABORT: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign grant   = grant_q;
    assign abort   = abort_q;
    assign rel_req = (state_q == ST_OWN) && |(bids & ~grant_q) && !lock_q && !ctl.retain;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] req_n,
    input logic         cyc_done,
    input logic         cyc_retain,
    input logic         rel_ack,
    input logic [N-1:0] irq_in,
    input logic [N-1:0] grant,
    input logic         rel_req,
    input logic         abort,
    input logic [N-1:0] irq_pend
);
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R2

    AST_REL_NEEDS_RIVAL: assert property (@(posedge clk) disable iff (rst)
        rel_req |-> ((grant != '0) && ((~req_n & ~grant) != '0))); // R5

    AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (rst)
        ((grant != '0) && cyc_done && rel_ack && !cyc_retain) |=> (grant == '0)); // R6

    AST_RETAIN_KEEPS: assert property (@(posedge clk) disable iff (rst)
        ((grant != '0) && cyc_done && cyc_retain) |=> (grant == $past(grant))); // R7

    AST_ABORT_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        abort |=> !abort); // R9

    AST_ABORT_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        abort |-> (grant == '0)); // R9

    AST_IRQ_SETS: assert property (@(posedge clk) disable iff (rst)
        (irq_in != '0) |=> ((irq_pend & $past(irq_in)) == $past(irq_in))); // R10
endmodule

bind bus_arbiter arb_checker #(.N(N)) u_arb_chk (
    .clk        (clk),
    .rst        (rst),
    .req_n      (req_n),
    .cyc_done   (cyc_done),
    .cyc_retain (cyc_retain),
    .rel_ack    (rel_ack),
    .irq_in     (irq_in),
    .grant      (grant),
    .rel_req    (rel_req),
    .abort      (abort),
    .irq_pend   (irq_pend)
);

// File: tb/test_bus_arbiter.sv
module test_bus_arbiter;
    localparam int N = 4;
    localparam int T = 256;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req_n = '1;
    logic         busy = 1'b0, done = 1'b0, retain = 1'b0, ack = 1'b0;
    logic [N-1:0] irq_in = '0, irq_clr = '0;
    logic [N-1:0] grant, irq_pend;
    logic         rel_req, abort;

    always #5 clk = ~clk;

    bus_arbiter #(.N(N), .TIMEOUT(T)) i_bus_arbiter (
        .clk(clk), .rst(rst), .req_n(req_n), .cyc_busy(busy), .cyc_done(done),
        .cyc_retain(retain), .rel_ack(ack), .irq_in(irq_in), .irq_clr(irq_clr),
        .grant(grant), .rel_req(rel_req), .abort(abort), .irq_pend(irq_pend)
    );

    // Reference model: 0 idle, 1 owned, 2 abort clock
    int m_state, m_owner, m_ptr, m_lock, m_cnt, m_abort;
    logic [N-1:0] m_irq;
    int n_cmp = 0, n_bad = 0;
    string tag = "R1";

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_state = 0; m_owner = -1; m_ptr = 0; m_lock = 0; m_cnt = 0; m_abort = 0; m_irq = '0;
    endtask

    task automatic compare();
        logic [N-1:0] eg, others;
        logic er;
        eg = (m_owner >= 0) ? N'(1 << m_owner) : '0;
        others = ~req_n & ~eg;
        er = (m_state == 1) && (others != '0) && (m_lock == 0) && !retain;
        chk("grant", 32'(grant), 32'(eg));
        chk("rel_req", 32'(rel_req), 32'(er));
        chk("abort", 32'(abort), 32'(m_abort));
        chk("irq_pend R10", 32'(irq_pend), 32'(m_irq));
    endtask

    task automatic model_update();
        if (rst) begin
            model_reset();
            return;
        end
        m_irq = (m_irq & ~irq_clr) | irq_in;
        m_abort = 0;
        case (m_state)
            0: begin
                for (int o = 0; o < N; o++) begin
                    int c;
                    c = (m_ptr + o) % N;
                    if (m_state == 0 && !req_n[c]) begin
                        m_state = 1; m_owner = c; m_ptr = (c + 1) % N; m_lock = 0; m_cnt = 0;
                    end
                end
            end
            1: begin
                if (busy && !done) begin
                    if (m_cnt == T - 1) begin
                        m_state = 2; m_owner = -1; m_lock = 0; m_cnt = 0; m_abort = 1;
                    end else m_cnt++;
                end else begin
                    m_cnt = 0;
                    if (done) begin
                        if (ack && !retain) begin
                            m_state = 0; m_owner = -1; m_lock = 0;
                        end else m_lock = retain;
                    end else if (m_lock == 0 && req_n[m_owner]) begin
                        m_state = 0; m_owner = -1;
                    end
                end
            end
            default: m_state = 0;
        endcase
    endtask

    // Inputs are set just after a falling edge; outputs compared 1 ns later.
    task automatic step();
        #1 compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic drive(logic [N-1:0] r, logic b, logic d, logic rt, logic a);
        req_n = r; busy = b; done = d; retain = rt; ack = a;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        tag = "R1";
        step(); step();
        rst = 1'b0;
        drive('1, 0, 0, 0, 0);

        // R3: everybody bids; rotate 0,1,2,3,0 via release handshakes
        tag = "R3";
        for (int k = 0; k < 5; k++) begin
            drive(4'b0000, 0, 0, 0, 0);
            drive(4'b0000, 1, 0, 0, 0);
            drive(4'b0000, 1, 1, 0, 1);
        end
        drive('1, 0, 0, 0, 0);
        drive('1, 0, 0, 0, 0);

        // R4: lone owner holds across cycles, done without ack
        tag = "R4";
        drive(4'b1101, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) begin
            drive(4'b1101, 1, 0, 0, 0);
            drive(4'b1101, 1, 1, 0, 0);
        end
        // R5: rival appears; rel_req raised, suppressed by retain in same clock
        tag = "R5";
        drive(4'b0101, 1, 0, 0, 0);
        drive(4'b0101, 1, 0, 1, 0);
        drive(4'b1101, 1, 0, 0, 0);
        // R6: release at cycle end
        tag = "R6";
        drive(4'b0101, 1, 1, 0, 1);
        drive(4'b0101, 0, 0, 0, 0);
        drive(4'b0101, 0, 0, 0, 0);

        // R7: retained cycle end with ack high keeps bus
        tag = "R7";
        drive(4'b0000, 1, 1, 1, 1);
        drive(4'b0000, 1, 0, 0, 1);
        drive(4'b0000, 0, 0, 0, 1);
        drive(4'b0000, 1, 1, 1, 1);
        drive(4'b0000, 1, 1, 0, 1);
        drive(4'b0000, 0, 0, 0, 0);

        // R8: owner drops its bid while idle
        tag = "R8";
        drive(4'b1111, 0, 0, 0, 0);
        drive(4'b1111, 0, 0, 0, 0);
        drive(4'b1011, 0, 0, 0, 0);
        drive(4'b1011, 1, 0, 0, 0);
        drive(4'b1111, 1, 0, 0, 0);
        drive(4'b1111, 0, 0, 0, 0);
        drive(4'b1111, 0, 0, 0, 0);

        // R9: stalled cycle with rival bidding
        tag = "R9";
        drive(4'b1110, 0, 0, 0, 0);
        for (int k = 0; k < T + 6; k++) drive(4'b0110, 1, 0, 0, 0);
        drive('1, 0, 0, 0, 0);
        drive('1, 0, 0, 0, 0);

        // R10: interrupt latch set, clear, both
        tag = "R10";
        irq_in = 4'b0101; drive('1, 0, 0, 0, 0);
        irq_in = '0;      drive('1, 0, 0, 0, 0);
        irq_clr = 4'b0001; drive('1, 0, 0, 0, 0);
        irq_in = 4'b0100; irq_clr = 4'b0100; drive('1, 0, 0, 0, 0);
        irq_in = '0; irq_clr = 4'b1111; drive('1, 0, 0, 0, 0);
        irq_clr = '0; drive('1, 0, 0, 0, 0);

        // R2: random mix
        tag = "R2";
        for (int k = 0; k < 4000; k++) begin
            irq_in  = N'($urandom_range(0, 15)) & N'($urandom_range(0, 15));
            irq_clr = N'($urandom_range(0, 15));
            drive(N'($urandom_range(0, 15)), 1'($urandom_range(0, 3) != 0),
                  1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 2) == 0),
                  1'($urandom_range(0, 1)));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule